// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Core

This block is the combinational heart of a field-configurable two-level logic device. A set of logic inputs is presented to an AND plane in both true and inverted form. Each product-term row of that plane has one configuration bit per literal column, and the row evaluates the AND of the literals it selects. Most product terms then enter a fully programmable OR plane, where each sum-term row may pick any subset of them. Each macrocell slot is given two sums: one for data and one for enable or clock. A small number of product terms stay outside the OR plane. One drives a global reset line and the others drive individual tri-state enables for bidirectional pins.

The configuration is held in a single shift chain, written one bit per clock. It only takes effect once a commit strobe marks it as complete. Until then, and from the moment a new load starts, every output is held at 0. Macrocell registers, pad drivers and programming voltages belong to the surrounding device and are not part of this block.

Top module: `prog_sop_array`

## Requirements
- R1: Input `i` owns two literal columns: column `2*i` is its true form and column `2*i+1` is its inverted form. A product term is 1 exactly when every literal column it selects is 1.
- R2: A product term with no literal selected evaluates to 1.
- R3: A product term that selects both the true and the inverted column of the same input evaluates to 0 for every input pattern.
- R4: AND-plane rows `0..N_PT-1` feed the OR plane. Row `N_PT` drives `reset_o` and row `N_PT+1+k` drives `oe_o[k]`. These extra rows are never visible to the OR plane.
- R5: A sum term is the OR of the product terms it selects. Any number of them, from none to all `N_PT`, may be selected, and a sum with none selected is 0.
- R6: OR-plane row `s` drives `data_sum_o[s]` and row `N_MC+s` drives `en_sum_o[s]`, for `s` in `0..N_MC-1`.
- R7: On each clock edge where `cfg_load_i` is 1, the chain shifts up one place and `cfg_bit_i` enters bit 0. AND-plane bit (row `t`, column `c`) sits at index `t*2*N_IN+c`. OR-plane bit (sum `s`, product `p`) sits at index `N_AND_BITS+s*N_PT+p`, where `N_AND_BITS=(N_PT+1+N_OE)*2*N_IN`.
- R8: All outputs are 0 while the configuration is not marked complete. A load cycle clears the complete flag, and a commit cycle without load sets it. When load and commit occur together, load wins.
- R9: An active `rst_ni` clears every configuration bit and the complete flag.
- R10: With `cfg_load_i` low, the stored configuration does not change, whatever `cfg_bit_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Shift enable for the configuration chain |
| cfg_bit_i | input | 1 | Serial configuration bit |
| cfg_commit_i | input | 1 | Marks the loaded configuration as complete |
| in_i | input | N_IN | Logic inputs to the AND plane |
| data_sum_o | output | N_MC | Data sum per macrocell |
| en_sum_o | output | N_MC | Enable/clock sum per macrocell |
| reset_o | output | 1 | Global reset product term |
| oe_o | output | N_OE | Per-pin output-enable product terms |

## Verification
The hardest cases to reach are the rows outside the OR plane, together with the contradictory-literal case. Both depend on a particular bit landing at an exact chain position, after hundreds of serial shifts. The bench works with a reduced array, keeps its own copy of each configuration, and shifts that copy in most-significant bit first. It then sweeps every input pattern and compares each one with a model evaluated from the bit layout rules. The configurations cover all-clear, all-set (every row contradictory), several sparse pseudo-random patterns and one hand-built pattern. The bench also exercises reset after a loaded image and a cycle where load and commit are both high.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // literal column of input idx; inv selects the complemented form
  function automatic int lit_col(input int idx, input bit inv);
    return 2 * idx + (inv ? 1 : 0);
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         bit_i,
  input  logic         commit_i,
  output logic [W-1:0] cfg_o,
  output logic         valid_o
);
  logic [W-1:0] cfg_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_i) cfg_q <= {cfg_q[W-2:0], bit_i};
      if (load_i)        valid_q <= 1'b0;
      else if (commit_i) valid_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign valid_o = valid_q;

  assert_shift_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cfg_q[0] == $past(bit_i)) && (cfg_q[W-1:1] == $past(cfg_q[W-2:0])));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_q);
  assert_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !load_i) |=> valid_q);
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int N_IN  = 39,
  parameter int N_ROW = 75,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_ROW*N_LIT-1:0] mask_i,
  output logic [N_ROW-1:0]       term_o
);
  logic [N_LIT-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[lit_col(i, 1'b0)] = in_i[i];
    assign lits[lit_col(i, 1'b1)] = ~in_i[i];
  end

  // unselected literal columns read as 1
  for (genvar t = 0; t < N_ROW; t++) begin : g_row
    assign term_o[t] = &(lits | ~mask_i[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_PT  = 64,
  parameter int N_SUM = 36
) (
  input  logic [N_PT-1:0]       pt_i,
  input  logic [N_SUM*N_PT-1:0] mask_i,
  output logic [N_SUM-1:0]      sum_o
);
  for (genvar s = 0; s < N_SUM; s++) begin : g_sum
    assign sum_o[s] = |(pt_i & mask_i[s*N_PT +: N_PT]);
  end
endmodule

// File: rtl/prog_sop_array.sv
module prog_sop_array #(
  parameter int N_IN = 39,
  parameter int N_PT = 64,
  parameter int N_MC = 18,
  parameter int N_OE = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_load_i,
  input  logic            cfg_bit_i,
  input  logic            cfg_commit_i,
  input  logic [N_IN-1:0] in_i,
  output logic [N_MC-1:0] data_sum_o,
  output logic [N_MC-1:0] en_sum_o,
  output logic            reset_o,
  output logic [N_OE-1:0] oe_o
);
  localparam int N_LIT     = 2 * N_IN;
  localparam int N_ROW     = N_PT + 1 + N_OE;
  localparam int N_SUM     = 2 * N_MC;
  localparam int AND_BITS  = N_ROW * N_LIT;
  localparam int OR_BITS   = N_SUM * N_PT;
  localparam int CFG_BITS  = AND_BITS + OR_BITS;

  logic [CFG_BITS-1:0] cfg;
  logic                valid;
  logic [N_ROW-1:0]    terms;
  logic [N_SUM-1:0]    sums;

  sop_cfg_chain #(.W(CFG_BITS)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .bit_i    (cfg_bit_i),
    .commit_i (cfg_commit_i),
    .cfg_o    (cfg),
    .valid_o  (valid)
  );

  sop_and_plane #(.N_IN(N_IN), .N_ROW(N_ROW)) u_and (
    .in_i   (in_i),
    .mask_i (cfg[AND_BITS-1:0]),
    .term_o (terms)
  );

  sop_or_plane #(.N_PT(N_PT), .N_SUM(N_SUM)) u_or (
    .pt_i   (terms[N_PT-1:0]),
    .mask_i (cfg[CFG_BITS-1:AND_BITS]),
    .sum_o  (sums)
  );

  assign data_sum_o = valid ? sums[N_MC-1:0]     : '0;
  assign en_sum_o   = valid ? sums[N_SUM-1:N_MC] : '0;
  assign reset_o    = valid & terms[N_PT];
  assign oe_o       = valid ? terms[N_ROW-1:N_PT+1] : '0;

  assert_dark_until_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_load_i) |-> (data_sum_o == '0 && en_sum_o == '0 && !reset_o && oe_o == '0));
endmodule

// File: tb/prog_sop_array_test.sv
`timescale 1ns/1ps
module prog_sop_array_test;
  localparam int NI = 3;
  localparam int NP = 4;
  localparam int NM = 2;
  localparam int NO = 2;
  localparam int NL = 2 * NI;
  localparam int AB = (NP + 1 + NO) * NL;
  localparam int TOT = AB + 2 * NM * NP;
  localparam int OW = 2 * NM + 1 + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, cbit = 1'b0, commit = 1'b0;
  logic [NI-1:0] x = '0;
  logic [NM-1:0] dsum, esum;
  logic rst_o;
  logic [NO-1:0] oe;
  logic [TOT-1:0] img;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_sop_array #(.N_IN(NI), .N_PT(NP), .N_MC(NM), .N_OE(NO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load), .cfg_bit_i(cbit),
    .cfg_commit_i(commit), .in_i(x), .data_sum_o(dsum), .en_sum_o(esum),
    .reset_o(rst_o), .oe_o(oe)
  );

  function automatic bit term_val(int t, logic [NI-1:0] v);
    bit r = 1;
    for (int i = 0; i < NI; i++) begin
      if (img[t*NL + 2*i] && !v[i]) r = 0;
      if (img[t*NL + 2*i + 1] && v[i]) r = 0;
    end
    return r;
  endfunction

  function automatic bit sum_val(int s, logic [NI-1:0] v);
    bit r = 0;
    for (int p = 0; p < NP; p++)
      if (img[AB + s*NP + p] && term_val(p, v)) r = 1;
    return r;
  endfunction

  function automatic logic [OW-1:0] model(logic [NI-1:0] v);
    logic [OW-1:0] e;
    for (int s = 0; s < NM; s++) begin
      e[s] = sum_val(s, v);
      e[NM + s] = sum_val(NM + s, v);
    end
    e[2*NM] = term_val(NP, v);
    for (int k = 0; k < NO; k++) e[2*NM + 1 + k] = term_val(NP + 1 + k, v);
    return e;
  endfunction

  task automatic check(string req, logic [OW-1:0] exp);
    logic [OW-1:0] act;
    act = {oe, rst_o, esum, dsum};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, x, act, exp);
    end
  endtask

  task automatic sweep(string req, bit live);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      x = v[NI-1:0];
      #1;
      check(req, live ? model(x) : '0);
    end
  endtask

  task automatic shift_img();
    for (int k = TOT - 1; k >= 0; k--) begin
      @(negedge clk);
      load = 1'b1;
      cbit = img[k];
    end
    @(negedge clk);
    load = 1'b0;
    #1;
    check("R8 dark during load", '0);
  endtask

  task automatic commit_cycle();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic run_cfg(string req);
    shift_img();
    sweep("R8 dark before commit", 1'b0);
    commit_cycle();
    sweep(req, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R9 reset outputs", '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 / R5: empty rows -> terms 1, sums 0
    img = '0;
    run_cfg("R2 R5 empty image");

    // R3: every row contradictory
    img = '1;
    run_cfg("R3 all literals");

    // R1 R4 R6: hand pattern
    img = '0;
    img[0*NL + 0] = 1'b1;                  // pt0 = x0
    img[1*NL + 3] = 1'b1;                  // pt1 = ~x1
    img[2*NL + 4] = 1'b1; img[2*NL + 1] = 1'b1; // pt2 = x2 & ~x0
    img[3*NL + 2] = 1'b1; img[3*NL + 3] = 1'b1; // pt3 contradictory
    img[NP*NL + 5] = 1'b1;                 // reset row = ~x2
    img[(NP+1)*NL + 2] = 1'b1;             // oe0 = x1
    img[(NP+2)*NL + 0] = 1'b1; img[(NP+2)*NL + 4] = 1'b1; // oe1 = x0&x2
    img[AB + 0*NP + 0] = 1'b1;             // data0 = pt0
    img[AB + 1*NP + 1] = 1'b1; img[AB + 1*NP + 2] = 1'b1; // data1
    img[AB + 2*NP + 3] = 1'b1;             // en0 = pt3 only
    for (int p = 0; p < NP; p++) img[AB + 3*NP + p] = 1'b1; // en1 all
    run_cfg("R1 R4 R6 hand image");

    // R10: noise on serial bit with load low
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cbit = k[0];
    end
    sweep("R10 hold without load", 1'b1);

    // R7: sparse pseudo-random images
    void'($urandom(17));
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < TOT; k++) img[k] = ($urandom % 3) == 0;
      run_cfg("R7 R1 R5 sparse image");
    end

    // R8: load and commit together keeps outputs dark
    @(negedge clk);
    load = 1'b1; commit = 1'b1; cbit = 1'b0;
    @(negedge clk);
    load = 1'b0; commit = 1'b0;
    #1;
    check("R8 load beats commit", '0);

    // R9: reset clears the image
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset dark", '0);
    @(negedge clk);
    rst_n = 1'b1;
    commit_cycle();
    img = '0;
    sweep("R9 cleared image", 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule